// File: doc/BRIEF.md
# Debug Command Gate with Run-Time Counter

This block sits between the decoder of a host debug link and the rest of a small microcontroller. Each decoded command byte arrives with a one-cycle valid strobe, an address operand and a data operand. The block decides whether the command may run. That decision depends on two things: whether the core is halted in debug mode, and whether the read-protect option input is set. The block answers one cycle later with either an accept pulse or a reject pulse. For accepted read commands it also places the result on a read-back bus.

The block owns the debug-mode flag. That flag is bit 7 of an 8-bit control register. A breakpoint or watchpoint event sets the flag. A control-register write sets or clears it. The block also owns a run-time counter. The counter counts clock cycles while the core runs, stops while the core is halted, and starts again from zero each time the core leaves debug mode.

Top module: `dbg_cmd_gate`

## Requirements
- R1: Code 01h and every code above 09h are rejected in every mode.
- R2: Outside debug mode, only codes 00h (revision read), 02h (status read), 03h (counter read) and 04h (control write) are accepted. Codes 05h to 09h are rejected.
- R3: In debug mode with read protection clear, every code from 00h to 09h except 01h is accepted.
- R4: In debug mode with read protection set, codes 06h (program counter write), 07h (program counter read) and 09h (register read) are rejected. Code 08h (register write) is accepted only when the address operand equals FLASH_CTRL_ADDR and the data operand equals MASS_ERASE_VAL.
- R5: An accepted 04h command loads data bits 6:0 into the control register and loads data bit 7 into the debug-mode flag. When read protection is set and the core is in debug mode, the flag stays 1 even if the written bit 7 is 0.
- R6: A breakpoint event sets the debug-mode flag on the next clock edge. The event takes priority over a control write in the same cycle.
- R7: Outside debug mode the counter increments once per clock cycle. In debug mode it holds its value.
- R8: The counter is 0 after reset, and it becomes 0 on the edge at which debug mode is left.
- R9: The counter stops at all ones and does not wrap.
- R10: A rejected command gives a reject pulse that lasts exactly one cycle. It changes neither the control register nor the debug-mode flag.
- R11: One cycle after an accepted read command, rdData holds the result. Code 00h returns REVISION. Code 02h returns a status word: bit 0 is the debug-mode flag, bit 1 is read protection, bit 2 is counter saturation. Code 03h returns the counter. Code 05h returns the control register, with the debug-mode flag in bit 7. rdData holds its value at all other times.
- R12: After reset the debug-mode flag is 0, both pulses are 0 and rdData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle strobe for a decoded command |
| cmdCode | input | 8 | Command byte |
| cmdAddr | input | ADDR_W | Register address operand |
| cmdData | input | DATA_W | Data operand |
| readProtect | input | 1 | Read-protect option bit |
| brkEvent | input | 1 | Breakpoint or watchpoint hit |
| cmdAccept | output | 1 | Command accepted, pulse one cycle after the strobe |
| cmdReject | output | 1 | Command rejected, pulse one cycle after the strobe |
| rdData | output | DATA_W | Read-back value |
| dbgMode | output | 1 | Debug-mode flag |

## Verification
The bench builds the block with CNT_W set to 6. This lets the counter reach its ceiling of 63 within a wait of a few dozen cycles, so the saturation bit and the hold at all ones are observed directly rather than being left unreached. FLASH_CTRL_ADDR is set to F8h and MASS_ERASE_VAL to 95h. The bench sends the protected register write three ways: with both operands right, with the wrong address, and with the wrong data. This covers both halves of the R4 condition. REVISION is set to a value other than the default, so that the revision read-back shows the parameter is actually passed through.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

  localparam logic [7:0] CMD_RD_REV  = 8'h00;
  localparam logic [7:0] CMD_RSVD    = 8'h01;
  localparam logic [7:0] CMD_RD_STAT = 8'h02;
  localparam logic [7:0] CMD_RD_CNT  = 8'h03;
  localparam logic [7:0] CMD_WR_CTRL = 8'h04;
  localparam logic [7:0] CMD_RD_CTRL = 8'h05;
  localparam logic [7:0] CMD_WR_PC   = 8'h06;
  localparam logic [7:0] CMD_RD_PC   = 8'h07;
  localparam logic [7:0] CMD_WR_REG  = 8'h08;
  localparam logic [7:0] CMD_RD_REG  = 8'h09;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_REV,
    RD_STAT,
    RD_CNT,
    RD_CTRL
  } rdSel_e;

  typedef struct packed {
    logic   accept;
    logic   reject;
    logic   wrCtrl;
    rdSel_e rdSel;
  } gateStrobe_t;

endpackage

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] FLASH_CTRL_ADDR = '1,
  parameter logic [DATA_W-1:0] MASS_ERASE_VAL = DATA_W'(8'h95)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              readProtect,
  input  logic              dbgMode,
  output gateStrobe_t       strobe
);

  logic runSubset;
  logic knownCode;
  logic protBlocked;
  logic allowed;

  always_comb begin
    runSubset = (cmdCode == CMD_RD_REV) || (cmdCode == CMD_RD_STAT) ||
                (cmdCode == CMD_RD_CNT) || (cmdCode == CMD_WR_CTRL);
    knownCode = (cmdCode <= CMD_RD_REG) && (cmdCode != CMD_RSVD);
    protBlocked = (cmdCode == CMD_WR_PC) || (cmdCode == CMD_RD_PC) ||
                  (cmdCode == CMD_RD_REG) ||
                  ((cmdCode == CMD_WR_REG) &&
                   !((cmdAddr == FLASH_CTRL_ADDR) && (cmdData == MASS_ERASE_VAL)));
    allowed = dbgMode ? (knownCode && !(readProtect && protBlocked)) : runSubset;
  end

  always_comb begin
    strobe.accept = cmdValid && allowed;
    strobe.reject = cmdValid && !allowed;
    strobe.wrCtrl = strobe.accept && (cmdCode == CMD_WR_CTRL);
    strobe.rdSel  = RD_NONE;
    if (strobe.accept) begin
      case (cmdCode)
        CMD_RD_REV:  strobe.rdSel = RD_REV;
        CMD_RD_STAT: strobe.rdSel = RD_STAT;
        CMD_RD_CNT:  strobe.rdSel = RD_CNT;
        CMD_RD_CTRL: strobe.rdSel = RD_CTRL;
        default:     strobe.rdSel = RD_NONE;
      endcase
    end
  end

  assert_bad_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && ((cmdCode == CMD_RSVD) || (cmdCode > CMD_RD_REG))) |-> strobe.reject);

  assert_run_subset_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && !dbgMode) |-> (cmdCode <= CMD_WR_CTRL && cmdCode != CMD_RSVD));

  assert_prot_block_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && dbgMode && readProtect) |->
      !((cmdCode == CMD_WR_PC) || (cmdCode == CMD_RD_PC) || (cmdCode == CMD_RD_REG)));

endmodule

// File: rtl/dbg_gate_datapath.sv
module dbg_gate_datapath
  import dbg_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter logic [DATA_W-1:0] REVISION = DATA_W'(16'h0A01)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [7:0]        ctrlWrData,
  input  logic              readProtect,
  input  logic              brkEvent,
  output logic              dbgMode,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic [DATA_W-1:0] rdData
);

  logic [6:0]       ctrlLow;
  logic [CNT_W-1:0] runCnt;
  logic             nextDbg;
  logic             dbgExit;
  logic             cntSat;
  logic [DATA_W-1:0] rdVal;

  always_comb begin
    if (brkEvent)
      nextDbg = 1'b1;
    else if (strobe.wrCtrl)
      nextDbg = (readProtect && dbgMode) ? 1'b1 : ctrlWrData[7];
    else
      nextDbg = dbgMode;
    dbgExit = dbgMode && !nextDbg;
    cntSat  = &runCnt;
  end

  always_comb begin
    case (strobe.rdSel)
      RD_REV:  rdVal = REVISION;
      RD_STAT: rdVal = DATA_W'({cntSat, readProtect, dbgMode});
      RD_CNT:  rdVal = DATA_W'(runCnt);
      RD_CTRL: rdVal = DATA_W'({dbgMode, ctrlLow});
      default: rdVal = rdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgMode   <= 1'b0;
      ctrlLow   <= '0;
      runCnt    <= '0;
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
      rdData    <= '0;
    end else begin
      dbgMode   <= nextDbg;
      cmdAccept <= strobe.accept;
      cmdReject <= strobe.reject;
      rdData    <= rdVal;
      if (strobe.wrCtrl)
        ctrlLow <= ctrlWrData[6:0];
      if (dbgExit)
        runCnt <= '0;
      else if (!dbgMode && !cntSat)
        runCnt <= runCnt + 1'b1;
    end
  end

  assert_keep_dbg_R5: assert property (@(posedge clk) disable iff (!rstN)
    (readProtect && dbgMode) |=> dbgMode);

  assert_evt_enter_R6: assert property (@(posedge clk) disable iff (!rstN)
    brkEvent |=> dbgMode);

  assert_hold_in_dbg_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dbgMode && nextDbg) |=> $stable(runCnt));

  assert_exit_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    dbgExit |=> (runCnt == '0));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cntSat && !dbgExit) |=> cntSat);

  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reject && !brkEvent) |=> ($stable(ctrlLow) && $stable(dbgMode)));

  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));

endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
  import dbg_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter logic [ADDR_W-1:0] FLASH_CTRL_ADDR = '1,
  parameter logic [DATA_W-1:0] MASS_ERASE_VAL = DATA_W'(8'h95),
  parameter logic [DATA_W-1:0] REVISION = DATA_W'(16'h0A01)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              readProtect,
  input  logic              brkEvent,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic [DATA_W-1:0] rdData,
  output logic              dbgMode
);

  gateStrobe_t strobe;

  dbg_cmd_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .FLASH_CTRL_ADDR(FLASH_CTRL_ADDR),
    .MASS_ERASE_VAL(MASS_ERASE_VAL)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .cmdValid(cmdValid),
    .cmdCode(cmdCode),
    .cmdAddr(cmdAddr),
    .cmdData(cmdData),
    .readProtect(readProtect),
    .dbgMode(dbgMode),
    .strobe(strobe)
  );

  dbg_gate_datapath #(
    .DATA_W(DATA_W),
    .CNT_W(CNT_W),
    .REVISION(REVISION)
  ) uPath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .ctrlWrData(cmdData[7:0]),
    .readProtect(readProtect),
    .brkEvent(brkEvent),
    .dbgMode(dbgMode),
    .cmdAccept(cmdAccept),
    .cmdReject(cmdReject),
    .rdData(rdData)
  );

endmodule

// File: tb/sim_dbg_cmd_gate.sv
module sim_dbg_cmd_gate;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W = 6;
  localparam logic [ADDR_W-1:0] FLASH_A = 8'hF8;
  localparam logic [DATA_W-1:0] ERASE_V = 16'h0095;
  localparam logic [DATA_W-1:0] REV_V = 16'h5A21;
  localparam int NVEC = 29;

  // {inDebug, protect, code, addr, data, expectAccept}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 8'h00, 16'h0000, 1'b1},
    {1'b0, 1'b0, 8'h01, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 8'h02, 8'h00, 16'h0000, 1'b1},
    {1'b0, 1'b0, 8'h03, 8'h00, 16'h0000, 1'b1},
    {1'b0, 1'b0, 8'h04, 8'h00, 16'h0000, 1'b1},
    {1'b0, 1'b0, 8'h05, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 8'h06, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 8'h07, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 8'h08, 8'hF8, 16'h0095, 1'b0},
    {1'b0, 1'b0, 8'h09, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 8'h0A, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b0, 8'hFF, 8'h00, 16'h0000, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h00, 16'h0000, 1'b1},
    {1'b1, 1'b0, 8'h01, 8'h00, 16'h0000, 1'b0},
    {1'b1, 1'b0, 8'h05, 8'h00, 16'h0000, 1'b1},
    {1'b1, 1'b0, 8'h06, 8'h00, 16'h1234, 1'b1},
    {1'b1, 1'b0, 8'h07, 8'h00, 16'h0000, 1'b1},
    {1'b1, 1'b0, 8'h08, 8'h10, 16'h0011, 1'b1},
    {1'b1, 1'b0, 8'h09, 8'h10, 16'h0000, 1'b1},
    {1'b1, 1'b0, 8'h0A, 8'h00, 16'h0000, 1'b0},
    {1'b1, 1'b1, 8'h06, 8'h00, 16'h1234, 1'b0},
    {1'b1, 1'b1, 8'h07, 8'h00, 16'h0000, 1'b0},
    {1'b1, 1'b1, 8'h09, 8'h10, 16'h0000, 1'b0},
    {1'b1, 1'b1, 8'h08, 8'hF8, 16'h0095, 1'b1},
    {1'b1, 1'b1, 8'h08, 8'hF8, 16'h0011, 1'b0},
    {1'b1, 1'b1, 8'h08, 8'h10, 16'h0095, 1'b0},
    {1'b1, 1'b1, 8'h05, 8'h00, 16'h0000, 1'b1},
    {1'b1, 1'b1, 8'h04, 8'h00, 16'h0080, 1'b1},
    {1'b1, 1'b1, 8'h01, 8'h00, 16'h0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdCode = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [DATA_W-1:0] cmdData = '0;
  logic readProtect = 1'b0;
  logic brkEvent = 1'b0;
  logic cmdAccept;
  logic cmdReject;
  logic [DATA_W-1:0] rdData;
  logic dbgMode;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dbg_cmd_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .FLASH_CTRL_ADDR(FLASH_A), .MASS_ERASE_VAL(ERASE_V), .REVISION(REV_V)
  ) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .readProtect(readProtect),
    .brkEvent(brkEvent), .cmdAccept(cmdAccept), .cmdReject(cmdReject),
    .rdData(rdData), .dbgMode(dbgMode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with results visible
  task automatic sendCmd(input logic [7:0] c, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cmdValid = 1'b1;
    cmdCode = c;
    cmdAddr = a;
    cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulseEvent();
    brkEvent = 1'b1;
    @(negedge clk);
    brkEvent = 1'b0;
  endtask

  task automatic setMode(input logic wantDbg);
    if (dbgMode !== wantDbg) begin
      if (wantDbg) pulseEvent();
      else begin
        readProtect = 1'b0;
        sendCmd(8'h04, '0, 16'h0000);
      end
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      vecCount++;
      missCount++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] firstCnt;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", {31'b0, dbgMode}, 0);
    check("R12", {30'b0, cmdAccept, cmdReject}, 0);
    check("R12", {16'b0, rdData}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R11 revision read
    sendCmd(8'h00, '0, '0);
    check("R11", {16'b0, rdData}, {16'b0, REV_V});

    // R6 breakpoint enters debug
    pulseEvent();
    check("R6", {31'b0, dbgMode}, 1);

    // R7 counter frozen in debug
    sendCmd(8'h03, '0, '0);
    firstCnt = rdData;
    sendCmd(8'h03, '0, '0);
    check("R7", {16'b0, rdData}, {16'b0, firstCnt});
    sendCmd(8'h02, '0, '0);
    check("R11", {30'b0, rdData[1:0]}, 32'h1);

    // R5 / R11 control write and read-back
    sendCmd(8'h04, '0, 16'h0085);
    sendCmd(8'h05, '0, '0);
    check("R11", {16'b0, rdData}, 32'h85);
    readProtect = 1'b1;
    sendCmd(8'h04, '0, 16'h0003);
    check("R5", {31'b0, dbgMode}, 1);
    sendCmd(8'h05, '0, '0);
    check("R5", {16'b0, rdData}, 32'h83);

    // R10 rejected command: one pulse, no state change
    sendCmd(8'h06, '0, 16'h0000);
    check("R10", {30'b0, cmdAccept, cmdReject}, 32'h1);
    check("R10", {16'b0, rdData}, 32'h83);
    @(negedge clk);
    check("R10", {31'b0, cmdReject}, 0);
    sendCmd(8'h08, 8'h10, ERASE_V);
    check("R4", {31'b0, cmdReject}, 1);
    sendCmd(8'h05, '0, '0);
    check("R10", {16'b0, rdData}, 32'h83);

    // R8 clear on exit, R7 counting
    readProtect = 1'b0;
    sendCmd(8'h04, '0, 16'h0000);
    check("R8", {31'b0, dbgMode}, 0);
    sendCmd(8'h03, '0, '0);
    check("R8", {16'b0, rdData}, 0);
    sendCmd(8'h03, '0, '0);
    check("R7", {16'b0, rdData}, 1);

    // R9 saturation
    repeat (80) @(negedge clk);
    sendCmd(8'h03, '0, '0);
    check("R9", {16'b0, rdData}, (1 << CNT_W) - 1);
    sendCmd(8'h02, '0, '0);
    check("R9", {16'b0, rdData}, 32'h4);

    // R6 event beats a same-cycle control write
    brkEvent = 1'b1;
    sendCmd(8'h04, '0, 16'h0000);
    brkEvent = 1'b0;
    check("R6", {31'b0, dbgMode}, 1);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      logic vDbg, vProt, vAcc;
      logic [7:0] vCode, vAddr;
      logic [15:0] vData;
      string tag;
      {vDbg, vProt, vCode, vAddr, vData, vAcc} = VEC[i];
      setMode(vDbg);
      readProtect = vProt;
      if (vCode == 8'h01 || vCode > 8'h09) tag = "R1";
      else if (!vDbg) tag = "R2";
      else if (vProt) tag = "R4";
      else tag = "R3";
      sendCmd(vCode, vAddr, vData);
      check(tag, {31'b0, cmdAccept}, {31'b0, vAcc});
      check(tag, {31'b0, cmdReject}, {31'b0, !vAcc});
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule